// File: doc/BRIEF.md
# Write-Strobe Timing Controller for a Parallel External Bus

This block runs one write access at a time on a parallel external memory bus. A request comes in on a valid/ready handshake and carries an address, write data and a width select (16 or 32 bits). The block then steps the bus through three phases: setup, strobe and hold. The length of each phase is set by a configuration field and counted in timing-clock cycles. While the strobe phase runs, a synchronous ready input from the external device can stretch it. When the hold phase ends, the block raises a one-cycle completion pulse.

The external bus clock can run at the timing-clock rate or at half that rate. A setup phase must begin on a cycle that opens with a rising bus-clock edge. When an accepted request would start on the wrong half, the block spends one quiet alignment cycle first. Between accesses all control lines stay inactive. The address lines hold the most recent address, except that address bit 0 is forced high.

The request port applies back-pressure simply. `req_ready` is high only while the controller is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge, and `req_ready` then stays low until the access has completed. The configuration inputs are plain levels that are captured at the transfer edge.

Top module: `xwr_strobe_ctrl`

## Requirements
- R1: In half-rate mode `bclk_en` is high on every second cycle after reset, starting with the first cycle; in full-rate mode it is always high. The first setup cycle of every access has `bclk_en` high.
- R2: If a request is accepted on an edge whose next cycle has `bclk_en` low, that next cycle is an alignment cycle. In an alignment cycle `cs_n`, `rnw`, `we0_n` and `we1_n` are high, `data_oe` is 0, `done` is 0 and `req_ready` is 0, and the setup phase follows directly.
- R3: Outside an access (idle, alignment and after reset), `addr_out[AW-1:1]` holds the upper bits of the last accepted address, or 0 if no access has been accepted yet. In the same periods `addr_out[0]` is 1. During an access `addr_out` equals the accepted address.
- R4: The setup, strobe and hold phases last `cfg_lead`, `cfg_active` and `cfg_trail` cycles respectively. A field value of 0 acts as 1.
- R5: `cs_n` and `rnw` are low from the first setup cycle through the last hold cycle, and high at all other times.
- R6: `we0_n` is low in exactly the strobe-phase cycles, including any extension cycles.
- R7: When `cfg_use_ready`=1 and `cfg_ready_async`=0 are captured, `bus_ready` is sampled at the end of each cycle that completes (lead+active+n-1) cycles, for n=1,2,…. Each low sample adds one more strobe cycle.
- R8: When `cfg_use_ready`=0 or `cfg_ready_async`=1 is captured, `bus_ready` has no effect on the length of any phase.
- R9: With `req_wide`=1, `we1_n` equals `we0_n`. With `req_wide`=0, `we1_n` carries address bit 0: the accepted address bit during an access, and 1 outside an access.
- R10: `data_oe[0]` is 1 from the first strobe cycle through the last hold cycle. `data_oe[1]` does the same but only for wide accesses. `data_out` equals the accepted write data whenever `data_oe[0]` is 1.
- R11: The timing fields, ready options and request fields are captured on the accepting edge. Changing them later has no effect on that access.
- R12: `done` is high for exactly the last hold cycle. `req_ready` is high exactly in idle cycles, so the earliest next acceptance is on the edge that closes the first idle cycle after `done`.
- R13: While `rst_n` is low and after its release, the controller is idle: `req_ready`=1, `cs_n`=`rnw`=`we0_n`=`we1_n`=1, `data_oe`=0, `done`=0, and `addr_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_rate | input | 1 | 1: bus clock runs at half the timing-clock rate |
| cfg_lead | input | CW | Setup-phase cycles |
| cfg_active | input | CW | Strobe-phase cycles |
| cfg_trail | input | CW | Hold-phase cycles |
| cfg_use_ready | input | 1 | Let `bus_ready` stretch the strobe phase |
| cfg_ready_async | input | 1 | 1 selects the asynchronous ready mode (not handled: ready ignored) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_wide | input | 1 | 1: 32-bit access, 0: 16-bit access |
| done | output | 1 | Pulse in the last hold cycle |
| bus_ready | input | 1 | Synchronous ready from the external device |
| bclk_en | output | 1 | Current cycle begins on a rising bus-clock edge |
| cs_n | output | 1 | Zone chip select, active low |
| rnw | output | 1 | Read/not-write |
| we0_n | output | 1 | Write enable, low half |
| we1_n | output | 1 | Write enable, high half (address bit 0 in 16-bit mode) |
| addr_out | output | AW | Address bus |
| data_out | output | DW | Data bus value |
| data_oe | output | DW/16 | Data output enable per 16-bit lane |

## Verification
Two events can land on adjacent edges. One is the end of an access, marked by `done`. The other is the acceptance of a request that has been waiting with `req_valid` held high. In half-rate mode an alignment decision is added on top. The bench holds `req_valid` high across back-to-back accesses of different lengths, so that the completion lands on both bus-clock halves. The cycle model then judges, on every clock, the gap that must follow, the alignment cycle that may follow, and the parked address seen between the two accesses. The same model is used to check the last ready sample against the strobe release when the ready stall ends exactly on the sampling cycle.

// File: rtl/xwr_pkg.sv
package xwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALIGN = 3'd1,
    ST_LEAD  = 3'd2,
    ST_ACT   = 3'd3,
    ST_TRAIL = 3'd4
  } xwr_state_e;

  // Counter load value for a phase field; a zero field behaves as one cycle.
  function automatic logic [7:0] phase_load(input logic [7:0] field);
    return (field == 8'd0) ? 8'd0 : field - 8'd1;
  endfunction

endpackage

// File: rtl/xwr_bus_phase.sv
module xwr_bus_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic bclk_en,
  output logic next_edge
);
  logic ph;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  // Current cycle opens on a rising bus-clock edge.
  assign bclk_en   = !half_rate || !ph;
  // Following cycle will open on a rising bus-clock edge.
  assign next_edge = !half_rate || ph;
endmodule

// File: rtl/xwr_seq.sv
module xwr_seq
  import xwr_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          next_edge,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_trail,
  input  logic          cfg_use_ready,
  input  logic          cfg_ready_async,
  input  logic          bus_ready,
  output xwr_state_e    state,
  output logic          last_cycle
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] act_ld_q;
  logic [CW-1:0] trail_ld_q;
  logic          wait_q;

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] f);
    logic [7:0] w;
    w = phase_load(8'(f));
    return w[CW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      act_ld_q   <= '0;
      trail_ld_q <= '0;
      wait_q     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          act_ld_q   <= ld(cfg_active);
          trail_ld_q <= ld(cfg_trail);
          wait_q     <= cfg_use_ready && !cfg_ready_async;
          cnt        <= ld(cfg_lead);
          state      <= next_edge ? ST_LEAD : ST_ALIGN;
        end
        ST_ALIGN: state <= ST_LEAD;
        ST_LEAD: begin
          if (cnt == '0) begin
            state <= ST_ACT;
            cnt   <= act_ld_q;
          end else cnt <= cnt - 1'b1;
        end
        ST_ACT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!(wait_q && !bus_ready)) begin
            state <= ST_TRAIL;
            cnt   <= trail_ld_q;
          end
        end
        ST_TRAIL: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign last_cycle = (state == ST_TRAIL) && (cnt == '0);
endmodule

// File: rtl/xwr_pins.sv
module xwr_pins
  import xwr_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 32,
  localparam int LANES = DW / 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  xwr_state_e       state,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_wide,
  output logic             cs_n,
  output logic             rnw,
  output logic             we0_n,
  output logic             we1_n,
  output logic [AW-1:0]    addr_out,
  output logic [DW-1:0]    data_out,
  output logic [LANES-1:0] data_oe
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          wide_q;
  logic          in_acc;
  logic          strobe;
  logic          drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wide_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_wdata;
      wide_q <= req_wide;
    end
  end

  assign in_acc = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_TRAIL);
  assign strobe = (state == ST_ACT);
  assign drive  = (state == ST_ACT) || (state == ST_TRAIL);

  assign cs_n     = !in_acc;
  assign rnw      = (state != ST_LEAD) && (state != ST_ACT) && (state != ST_TRAIL);
  assign we0_n    = !strobe;
  assign addr_out = in_acc ? addr_q : {addr_q[AW-1:1], 1'b1};
  assign we1_n    = wide_q ? !strobe : addr_out[0];
  assign data_out = data_q;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g == 0) begin : g_base
        assign data_oe[g] = drive;
      end else begin : g_upper
        assign data_oe[g] = drive && wide_q;
      end
    end
  endgenerate
endmodule

// File: rtl/xwr_strobe_ctrl.sv
module xwr_strobe_ctrl
  import xwr_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 32,
  parameter int CW = 4,
  localparam int LANES = DW / 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_rate,
  input  logic [CW-1:0]    cfg_lead,
  input  logic [CW-1:0]    cfg_active,
  input  logic [CW-1:0]    cfg_trail,
  input  logic             cfg_use_ready,
  input  logic             cfg_ready_async,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_wide,
  output logic             done,
  input  logic             bus_ready,
  output logic             bclk_en,
  output logic             cs_n,
  output logic             rnw,
  output logic             we0_n,
  output logic             we1_n,
  output logic [AW-1:0]    addr_out,
  output logic [DW-1:0]    data_out,
  output logic [LANES-1:0] data_oe
);
  xwr_state_e state;
  logic       next_edge;
  logic       accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  xwr_bus_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_rate (half_rate),
    .bclk_en   (bclk_en),
    .next_edge (next_edge)
  );

  xwr_seq #(.CW(CW)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .accept          (accept),
    .next_edge       (next_edge),
    .cfg_lead        (cfg_lead),
    .cfg_active      (cfg_active),
    .cfg_trail       (cfg_trail),
    .cfg_use_ready   (cfg_use_ready),
    .cfg_ready_async (cfg_ready_async),
    .bus_ready       (bus_ready),
    .state           (state),
    .last_cycle      (done)
  );

  xwr_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .state     (state),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_wide  (req_wide),
    .cs_n      (cs_n),
    .rnw       (rnw),
    .we0_n     (we0_n),
    .we1_n     (we1_n),
    .addr_out  (addr_out),
    .data_out  (data_out),
    .data_oe   (data_oe)
  );
endmodule

// File: rtl/xwr_strobe_ctrl_chk.sv
module xwr_strobe_ctrl_chk #(
  parameter int AW = 19,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done,
  input logic             bclk_en,
  input logic             cs_n,
  input logic             rnw,
  input logic             we0_n,
  input logic [AW-1:0]    addr_out,
  input logic [LANES-1:0] data_oe
);
  p_start_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> bclk_en);
  p_park_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> addr_out[0]);
  p_rnw_with_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rnw == cs_n);
  p_we_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we0_n |-> !cs_n);
  p_oe_with_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we0_n) |-> data_oe[0]);
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_then_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cs_n && req_ready));
  p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);
endmodule

bind xwr_strobe_ctrl xwr_strobe_ctrl_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .bclk_en   (bclk_en),
  .cs_n      (cs_n),
  .rnw       (rnw),
  .we0_n     (we0_n),
  .addr_out  (addr_out),
  .data_oe   (data_oe)
);

// File: tb/xwr_strobe_ctrl_test.sv
module xwr_strobe_ctrl_test;
  localparam int AW = 19;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_rate = 1'b0;
  logic [CW-1:0] cfg_lead = 4'd1, cfg_active = 4'd1, cfg_trail = 4'd1;
  logic cfg_use_ready = 1'b0, cfg_ready_async = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_wide = 1'b0;
  logic done, bus_ready, bclk_en, cs_n, rnw, we0_n, we1_n;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] data_out;
  logic [1:0] data_oe;

  int checks = 0;
  int errors = 0;
  int stall_left = 0;
  int wd = 0;
  string ctx = "R13";

  initial bus_ready = 1'b1;
  always #10 clk = ~clk;

  xwr_strobe_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
    .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
    .cfg_use_ready(cfg_use_ready), .cfg_ready_async(cfg_ready_async),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wide(req_wide), .done(done),
    .bus_ready(bus_ready), .bclk_en(bclk_en), .cs_n(cs_n), .rnw(rnw),
    .we0_n(we0_n), .we1_n(we1_n), .addr_out(addr_out),
    .data_out(data_out), .data_oe(data_oe)
  );

  // Behavioural reference: elapsed-cycle count against phase boundaries.
  bit m_busy, m_align, m_wide, m_wait;
  int t, ml, ma, mt, mk, cyc;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  function automatic int at_least1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_align = 0; t = 0; mk = 0; cyc = 0;
      m_addr = '0; m_data = '0; m_wide = 0;
    end else begin
      if (m_align) begin
        m_align = 0; m_busy = 1; t = 0;
      end else if (m_busy) begin
        if (t == ml + ma + mk - 1 && m_wait && !bus_ready) mk++;
        t++;
        if (t == ml + ma + mk + mt) m_busy = 0;
      end else if (req_valid) begin
        ml = at_least1(int'(cfg_lead));
        ma = at_least1(int'(cfg_active));
        mt = at_least1(int'(cfg_trail));
        mk = 0;
        m_wait = cfg_use_ready && !cfg_ready_async;
        m_addr = req_addr; m_data = req_wdata; m_wide = req_wide;
        if (half_rate && cyc % 2 == 0) m_align = 1;
        else begin m_busy = 1; t = 0; end
      end
      cyc++;
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual %h expected %h at %0t", tag, ctx, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit acc, act_ph;
    logic [AW-1:0] ea;
    acc = m_busy;
    act_ph = acc && t >= ml && t < ml + ma + mk;
    ea = acc ? m_addr : {m_addr[AW-1:1], 1'b1};
    chk("R1", "bclk_en", 64'(bclk_en), 64'(!half_rate || (cyc % 2 == 0)));
    chk("R5", "cs_n", 64'(cs_n), 64'(!acc));
    chk("R5", "rnw", 64'(rnw), 64'(!acc));
    chk("R6", "we0_n", 64'(we0_n), 64'(!act_ph));
    chk("R9", "we1_n", 64'(we1_n), 64'(m_wide ? !act_ph : ea[0]));
    chk("R3", "addr_out", 64'(addr_out), 64'(ea));
    chk("R10", "data_oe", 64'(data_oe),
        64'({acc && t >= ml && m_wide, acc && t >= ml}));
    if (acc && t >= ml) chk("R10", "data_out", 64'(data_out), 64'(m_data));
    chk("R12", "done", 64'(done), 64'(acc && t == ml + ma + mk + mt - 1));
    chk("R12", "req_ready", 64'(req_ready), 64'(!acc && !m_align));
    #2;
    if (stall_left > 0 && !we0_n) begin bus_ready = 1'b0; stall_left--; end
    else bus_ready = 1'b1;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #3;
  endtask

  task automatic set_cfg(input int l, input int a, input int tr, input bit use_r, input bit asy);
    cfg_lead = CW'(l); cfg_active = CW'(a); cfg_trail = CW'(tr);
    cfg_use_ready = use_r; cfg_ready_async = asy;
  endtask

  task automatic write1(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit w,
                        input int stall, input bit scramble);
    req_addr = a; req_wdata = d; req_wide = w; req_valid = 1'b1;
    stall_left = stall;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    if (scramble) begin
      // R11: fields change after acceptance
      set_cfg(9, 9, 9, 1, 0);
      req_addr = ~a; req_wdata = ~d; req_wide = ~w;
    end
    while (!done) tick();
    tick();
    tick();
  endtask

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    ctx = "R4"; set_cfg(1, 1, 1, 0, 0);
    write1(19'h00012, 32'h1111_2222, 0, 0, 0);
    set_cfg(2, 3, 2, 0, 0);
    write1(19'h2A5A5, 32'hDEAD_BEEF, 1, 0, 0);
    ctx = "R4 zero fields"; set_cfg(0, 0, 0, 0, 0);
    write1(19'h00401, 32'h0000_5A5A, 0, 0, 0);
    ctx = "R7"; set_cfg(1, 3, 1, 1, 0);
    write1(19'h01000, 32'hCAFE_0001, 1, 5, 0);
    set_cfg(2, 1, 2, 1, 0);
    write1(19'h01003, 32'hCAFE_0002, 0, 2, 0);
    ctx = "R8 ready off"; set_cfg(1, 2, 1, 0, 0);
    write1(19'h03333, 32'h0BAD_0003, 1, 6, 0);
    ctx = "R8 async"; set_cfg(1, 2, 1, 1, 1);
    write1(19'h03334, 32'h0BAD_0004, 1, 6, 0);
    ctx = "R11"; set_cfg(2, 2, 2, 0, 0);
    write1(19'h05555, 32'h1234_5678, 1, 0, 1);
    ctx = "R2 half rate"; half_rate = 1'b1; set_cfg(1, 2, 1, 0, 0);
    write1(19'h06001, 32'h0000_0006, 0, 0, 0);
    tick();
    write1(19'h06002, 32'h0000_0007, 1, 0, 0);
    ctx = "R12 back-to-back"; set_cfg(1, 1, 1, 0, 0);
    req_addr = 19'h07001; req_wdata = 32'h7777_0001; req_wide = 1'b0; req_valid = 1'b1;
    while (!req_ready) tick();
    tick();
    req_addr = 19'h07FFE; req_wdata = 32'h7777_0002; req_wide = 1'b1;
    set_cfg(2, 1, 2, 0, 0);
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    while (!done) tick();
    tick(); tick();
    ctx = "R13 reset"; rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick(); tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule